// File: doc/BRIEF.md
# Multiprocessor-Wakeup Serial Receiver Control

This block is the receive side of an asynchronous serial port, together with the control register that it shares with a transmitter kept outside the block. A bus-side register interface gives access to an 8-bit control register, a status register and the received-data register. The receiver oversamples the line at sixteen ticks per bit. A frame is a start bit, eight data bits with the least significant bit first, one multiprocessor bit and a stop bit.

In a network of several listeners, a node can arm a wakeup bit. While that bit is armed, every frame whose multiprocessor bit is 0 is treated as data meant for another node and is dropped without a trace. The first frame whose multiprocessor bit is 1 is an address frame. It disarms the wakeup bit and is handled as an ordinary frame, as is every frame after it, until software arms the bit again. The interrupt outputs are the status flags gated by their enable bits. The transmit-empty and transmit-end conditions come in from the external transmitter.

Top module: `mprx_top`

## Requirements
- R1: After reset the control register, the three receive flags and the data register read 0, and all four interrupt outputs are low.
- R2: The control register at address 0 reads back what was written. From bit 7 down to bit 0 it holds: transmit interrupt enable, receive interrupt enable, transmit enable, receive enable, wakeup arm, transmit-end interrupt enable, and the two clock-select bits [1:0].
- R3: Clock select 00 gives internal clock with the clock pin undriven (`ext_clk_sel`=0, `sck_drive`=0). Clock select 01 gives internal clock with the clock driven out (0,1). Clock select 10 and 11 give external clock with the pin undriven (1,0).
- R4: `tx_run` follows transmit enable and `rx_run` follows receive enable. A frame sent while receive enable is 0 changes no flag and no data.
- R5: A complete frame loads the data register at address 2 (LSB first on the line) and sets rx_full, which is status bit 0 at address 1. The flag rises at the stop-bit sample, mid-bit, 16 ticks per bit.
- R6: A stop bit sampled as 0 sets the framing-error flag (status bit 2).
- R7: A frame that completes while rx_full is set sets the overrun flag (status bit 1) and leaves the data register unchanged.
- R8: Writing 0 to a status flag clears it only if a status read has returned that flag as 1 since it was last set. Writing 1 has no effect. Status bits 3 and 4 show the transmit-empty and transmit-end inputs and are read-only.
- R9: `irq_rx_full` = rx_full AND receive interrupt enable. `irq_rx_err` = (overrun OR framing error) AND receive interrupt enable. `irq_tx_empty` = transmit-empty input AND transmit interrupt enable. `irq_tx_end` = transmit-end input AND transmit-end interrupt enable.
- R10: While wakeup is armed, a frame with multiprocessor bit 0 changes no flag and no data, even when its stop bit is 0.
- R11: A frame with multiprocessor bit 1 clears the wakeup arm bit in hardware and is itself handled normally, as are the frames after it.
- R12: Clearing receive enable in the middle of a frame returns the receiver to idle and leaves every flag and the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial receive line |
| tx_empty_in | input | 1 | Transmit data register empty, from transmitter |
| tx_end_in | input | 1 | Transmission ended, from transmitter |
| irq_tx_empty | output | 1 | Transmit-empty request |
| irq_rx_full | output | 1 | Receive-data-full request |
| irq_rx_err | output | 1 | Receive-error request |
| irq_tx_end | output | 1 | Transmit-end request |
| tx_run | output | 1 | Transmitter enabled |
| rx_run | output | 1 | Receiver enabled |
| ext_clk_sel | output | 1 | External clock selected |
| sck_drive | output | 1 | Clock pin driven as output |

## Verification
If the wakeup arm bit stays set after an address frame, the next data frames vanish. `irq_rx_full` then stays low one frame time (176 ticks) after it should have risen, and a read of address 0 still shows bit 3. If the filter leaks, a dropped frame sets rx_full or framing error at its stop sample. That shows on `irq_rx_full` or `irq_rx_err` in the very next cycle. Wrong bookkeeping of which flags have been read shows up on the first write of 0 to the status register. The flag either falls too early or stays up, and the interrupt output follows one cycle later.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic       tie;
    logic       rie;
    logic       te;
    logic       re;
    logic       mpie;
    logic       teie;
    logic [1:0] cks;
  } ctrl_t;

  // {external clock select, clock pin driven}
  function automatic logic [1:0] clk_route(input logic [1:0] cks);
    return {cks[1], (cks == 2'b01)};
  endfunction

  function automatic logic [7:0] pack_status(input logic full, input logic ovr,
                                             input logic fer, input logic txe,
                                             input logic txend);
    return {3'b000, txend, txe, fer, ovr, full};
  endfunction

endpackage

// File: rtl/mprx_ctrl.sv
module mprx_ctrl
  import mprx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       wake,
  output ctrl_t      q
);

  logic [7:0] q_bits;
  assign q_bits = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr) q <= ctrl_t'(wdata);
      if (wake) q.mpie <= 1'b0;
    end
  end

  // R11: an address frame disarms wakeup, even against a software write
  a_r11_wake_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !q.mpie);

  // R2: a plain write lands in full
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wake) |=> (q_bits == $past(wdata)));

endmodule

// File: rtl/mprx_shift.sv
module mprx_shift
  import mprx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              os_tick,
  input  logic              rxd,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_mpb,
  output logic              frame_stop_ok
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] MP_IDX   = IDX_W'(DATA_W);

  logic rxd_s;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
      assign rxd_s = sync_q[SYNC_STAGES-1];
    end else begin : g_nosync
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b1;
        else        sync_q <= rxd;
      end
      assign rxd_s = sync_q;
    end
  endgenerate

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              mpb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      mpb_q   <= 1'b0;
    end else if (!rx_en) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else if (os_tick) begin
      case (state_q)
        RX_IDLE: begin
          if (!rxd_s) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rxd_s ? RX_IDLE : RX_BITS;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == LAST_CNT) begin
            cnt_q <= '0;
            if (idx_q == MP_IDX) begin
              mpb_q   <= rxd_s;
              state_q <= RX_STOP;
            end else begin
              shreg_q <= {rxd_s, shreg_q[DATA_W-1:1]};
              idx_q   <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == LAST_CNT) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign frame_done    = rx_en && os_tick && (state_q == RX_STOP) && (cnt_q == LAST_CNT);
  assign frame_data    = shreg_q;
  assign frame_mpb     = mpb_q;
  assign frame_stop_ok = rxd_s;

  // R12: losing the receive enable drops any frame in progress
  a_r12_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state_q == RX_IDLE));

  // R5: a frame can only end after the start and bit phases
  a_r5_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(state_q == RX_STOP || state_q == RX_BITS));

endmodule

// File: rtl/mprx_flags.sv
module mprx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_mpb,
  input  logic              frame_stop_ok,
  input  logic              mpie,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [2:0]        stat_wdata,
  output logic              rx_full,
  output logic              overrun,
  output logic              frame_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              wake
);

  // flag vector order: [0] full, [1] overrun, [2] framing
  logic [2:0] flag_q, seen_q, set_v, clr_v;
  logic [DATA_W-1:0] data_q;
  logic accept, clr_any;

  assign accept  = frame_done && (!mpie || frame_mpb);
  assign wake    = frame_done && mpie && frame_mpb;
  assign set_v   = {accept && !frame_stop_ok, accept && flag_q[0], accept && !flag_q[0]};
  assign clr_v   = {3{stat_wr}} & ~stat_wdata & seen_q;
  assign clr_any = |clr_v;

  generate
    for (genvar i = 0; i < 3; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[i] <= 1'b0;
          seen_q[i] <= 1'b0;
        end else if (set_v[i]) begin
          flag_q[i] <= 1'b1;
          seen_q[i] <= 1'b0;
        end else if (clr_v[i]) begin
          flag_q[i] <= 1'b0;
          seen_q[i] <= 1'b0;
        end else if (stat_rd && flag_q[i]) begin
          seen_q[i] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (set_v[0]) data_q <= frame_data;
  end

  assign rx_full   = flag_q[0];
  assign overrun   = flag_q[1];
  assign frame_err = flag_q[2];
  assign rx_data   = data_q;

  // R10: a dropped frame leaves every flag and the data alone
  a_r10_discard_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mpie && !frame_mpb && !clr_any) |=> $stable({flag_q, data_q}));

  // R7: overrun keeps the old byte
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flag_q[0]) |=> (flag_q[1] && $stable(data_q)));

  // R6: bad stop bit raises the framing flag
  a_r6_stop_error: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !frame_stop_ok) |=> flag_q[2]);

  // R8: an unread flag survives any write
  a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !seen_q[0]) |=> flag_q[0]);

endmodule

// File: rtl/mprx_top.sv
module mprx_top
  import mprx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       tx_empty_in,
  input  logic       tx_end_in,
  output logic       irq_tx_empty,
  output logic       irq_rx_full,
  output logic       irq_rx_err,
  output logic       irq_tx_end,
  output logic       tx_run,
  output logic       rx_run,
  output logic       ext_clk_sel,
  output logic       sck_drive
);

  localparam int DATA_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  ctrl_t c;
  logic wake, frame_done, frame_mpb, frame_stop_ok;
  logic rx_full, overrun, frame_err;
  logic [DATA_W-1:0] frame_data, rx_data;
  logic ctrl_wr, stat_wr, stat_rd;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  mprx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata), .wake(wake), .q(c)
  );

  mprx_shift #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .rx_en(c.re), .os_tick(os_tick), .rxd(rxd),
    .frame_done(frame_done), .frame_data(frame_data), .frame_mpb(frame_mpb),
    .frame_stop_ok(frame_stop_ok)
  );

  mprx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .frame_mpb(frame_mpb), .frame_stop_ok(frame_stop_ok), .mpie(c.mpie),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(bus_wdata[2:0]),
    .rx_full(rx_full), .overrun(overrun), .frame_err(frame_err),
    .rx_data(rx_data), .wake(wake)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = c;
      A_STAT:  bus_rdata = pack_status(rx_full, overrun, frame_err, tx_empty_in, tx_end_in);
      A_DATA:  bus_rdata = rx_data;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_rx_full  = rx_full && c.rie;
  assign irq_rx_err   = (overrun || frame_err) && c.rie;
  assign irq_tx_empty = tx_empty_in && c.tie;
  assign irq_tx_end   = tx_end_in && c.teie;
  assign tx_run       = c.te;
  assign rx_run       = c.re;
  assign {ext_clk_sel, sck_drive} = clk_route(c.cks);

  // R9: no receive request while receive interrupts are disabled
  a_r9_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx_full || irq_rx_err) |-> c.rie);

endmodule

// File: tb/test_mprx_top.sv
module test_mprx_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic os_tick = 1'b1, rxd = 1'b1, tx_empty_in = 0, tx_end_in = 0;
  logic irq_tx_empty, irq_rx_full, irq_rx_err, irq_tx_end;
  logic tx_run, rx_run, ext_clk_sel, sck_drive;

  mprx_top i_mprx_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .os_tick(os_tick), .rxd(rxd),
    .tx_empty_in(tx_empty_in), .tx_end_in(tx_end_in), .irq_tx_empty(irq_tx_empty),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err), .irq_tx_end(irq_tx_end),
    .tx_run(tx_run), .rx_run(rx_run), .ext_clk_sel(ext_clk_sel), .sck_drive(sck_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit checking = 0, finished = 0;

  // reference model state
  logic [7:0] m_ctrl = 0, m_data = 0;
  bit m_full = 0, m_ovr = 0, m_fer = 0;
  bit [2:0] m_seen = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {3'b000, tx_end_in, tx_empty_in, m_fer, m_ovr, m_full};
  endfunction

  // per-clock comparison of every output against the model
  always @(negedge clk) begin
    #2;
    if (checking && !finished) begin
      chk("R9 irq_rx_full", irq_rx_full, m_full & m_ctrl[6]);
      chk("R9 irq_rx_err", irq_rx_err, (m_ovr | m_fer) & m_ctrl[6]);
      chk("R9 irq_tx_empty", irq_tx_empty, tx_empty_in & m_ctrl[7]);
      chk("R9 irq_tx_end", irq_tx_end, tx_end_in & m_ctrl[2]);
      chk("R4 tx_run", tx_run, m_ctrl[5]);
      chk("R4 rx_run", rx_run, m_ctrl[4]);
      chk("R3 ext_clk_sel", ext_clk_sel, m_ctrl[1]);
      chk("R3 sck_drive", sck_drive, m_ctrl[1:0] == 2'b01);
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a == 0) m_ctrl = d;
    if (a == 1)
      for (int b = 0; b < 3; b++)
        if (!d[b] && m_seen[b]) begin
          m_seen[b] = 0;
          if (b == 0) m_full = 0;
          if (b == 1) m_ovr = 0;
          if (b == 2) m_fer = 0;
        end
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    logic [7:0] e;
    bus_rd = 1; bus_addr = a;
    #1;
    e = (a == 0) ? m_ctrl : (a == 1) ? m_status() : (a == 2) ? m_data : 8'h00;
    chk(tag, bus_rdata, e);
    @(negedge clk);
    bus_rd = 0;
    if (a == 1) m_seen = m_seen | {m_fer, m_ovr, m_full};
  endtask

  task automatic model_frame(input logic [7:0] d, input bit mp, input bit stop);
    if (!m_ctrl[4]) return;
    if (m_ctrl[3] && !mp) return;
    if (m_ctrl[3]) m_ctrl[3] = 0;
    if (m_full) begin m_ovr = 1; m_seen[1] = 0; end
    else begin m_data = d; m_full = 1; m_seen[0] = 0; end
    if (!stop) begin m_fer = 1; m_seen[2] = 0; end
  endtask

  // frame on the line, 16 cycles per bit; stop sample lands 170 cycles after the start edge
  task automatic send_frame(input logic [7:0] d, input bit mp, input bit stop);
    rxd = 0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    rxd = mp;
    repeat (16) @(negedge clk);
    rxd = stop;
    repeat (11) @(negedge clk);
    model_frame(d, mp, stop);
    repeat (5) @(negedge clk);
    rxd = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_all();
    bus_read(1, "R8 status before clear");
    bus_write(1, 8'h00);
    bus_read(1, "R8 status after clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checking = 1;
    // R1 reset state
    bus_read(0, "R1 ctrl reset");
    bus_read(1, "R1 status reset");
    bus_read(2, "R1 data reset");
    // R2 / R3 register and clock routing
    bus_write(0, 8'hA5); bus_read(0, "R2 ctrl readback A5");
    bus_write(0, 8'h5A); bus_read(0, "R2 ctrl readback 5A");
    bus_write(0, 8'h01); bus_read(0, "R3 cks 01");
    bus_write(0, 8'h02); bus_read(0, "R3 cks 10");
    bus_write(0, 8'h03); bus_read(0, "R3 cks 11");
    bus_write(0, 8'h00); bus_read(0, "R3 cks 00");
    // R9 transmit requests
    bus_write(0, 8'h84);
    tx_empty_in = 1; repeat (3) @(negedge clk);
    tx_end_in = 1; repeat (3) @(negedge clk);
    bus_read(1, "R8 read-only tx bits");
    bus_write(0, 8'h00); repeat (2) @(negedge clk);
    tx_empty_in = 0; tx_end_in = 0;
    // R4 receiver disabled ignores frames
    bus_write(0, 8'h40);
    send_frame(8'h99, 0, 1);
    bus_read(1, "R4 no flags with receiver off");
    bus_read(2, "R4 no data with receiver off");
    // R5 normal frame
    bus_write(0, 8'h50);
    send_frame(8'h3C, 0, 1);
    bus_read(2, "R5 data LSB first");
    // R8 write 0 without prior read does nothing
    bus_write(1, 8'h00);
    bus_read(1, "R8 unread flag kept");
    bus_write(1, 8'h07);
    bus_read(1, "R8 write one no effect");
    bus_write(1, 8'h00);
    bus_read(1, "R8 cleared after read");
    // R7 overrun
    send_frame(8'h11, 0, 1);
    send_frame(8'h22, 0, 1);
    bus_read(2, "R7 old data kept");
    clear_all();
    // R6 framing error
    send_frame(8'hE7, 0, 0);
    bus_read(1, "R6 framing flag");
    bus_write(1, 8'h00);
    bus_read(1, "R6 cleared");
    // R10 armed wakeup drops data frames
    bus_write(0, 8'h58);
    send_frame(8'h77, 0, 1);
    send_frame(8'h78, 0, 0);
    bus_read(1, "R10 no flag from dropped frames");
    bus_read(2, "R10 data unchanged");
    bus_read(0, "R10 still armed");
    // R11 address frame wakes and is received
    send_frame(8'h42, 1, 1);
    bus_read(0, "R11 arm bit cleared");
    bus_read(2, "R11 address byte stored");
    clear_all();
    send_frame(8'h43, 0, 1);
    bus_read(2, "R11 later data frame stored");
    clear_all();
    // R12 abort mid-frame
    rxd = 0;
    repeat (60) @(negedge clk);
    bus_write(0, 8'h40);
    rxd = 1;
    repeat (200) @(negedge clk);
    bus_write(0, 8'h50);
    repeat (20) @(negedge clk);
    bus_read(1, "R12 no flag after abort");
    bus_read(2, "R12 data unchanged after abort");
    send_frame(8'h5D, 0, 1);
    bus_read(2, "R12 receiver works after abort");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule